// File: doc/BRIEF.md
# Chirp Symbol Generator

This block synthesizes linear frequency sweeps ("chirps") of 2^SF complex samples and emits them as packed I/Q words on a valid/ready output stream. A symbol value picks where in the band the sweep begins; the frequency then walks across the band one bin per sample and wraps at the edge, so each symbol value is a cyclic shift of the same base sweep. A direction bit chooses a rising or falling sweep, and a bandwidth select scales the phase step against the fixed sample clock without altering the sample count.

A host pulses start with the spreading factor, symbol, direction and bandwidth on the inputs. In single-shot mode the stream obeys back-pressure: a sample waits in place until it is taken. When the repeat input is high, the generator runs at one sample per clock regardless of the consumer. A sample the consumer refuses is dropped, and a sticky overflow flag records the loss. The repeat input, symbol and direction are sampled again at every symbol boundary, so a stream of different symbols can be sent back to back with a phase that continues across the boundary. Sine and cosine come from a quarter-wave table built when the design is elaborated.

Top module: `chirp_symbol_gen`

## Requirements
- R1: A start pulse while busy_o is low makes busy_o and m_valid_o high on the next cycle. The first sample shown is always I=0x7FFF, Q=0x0000, because the phase restarts at zero.
- R2: A symbol holds exactly 2^SF accepted samples. An SF input below 5 acts as 5, and one above 12 acts as 12.
- R3: For sample n, the frequency index k(n) of a rising sweep is (symbol + n) mod 2^SF. The phase is a 16-bit accumulator that starts at 0, and each sample adds k(n) shifted left by (14 - SF + bw). The top 8 phase bits address a 256-point circle. I = round(32767*cos) is in bits 31:16 and Q = round(32767*sin) is in bits 15:0, both signed and accurate to 1 LSB.
- R4: With up_i=0 the index is mirrored to 2^SF - 1 - ((symbol + n) mod 2^SF). The symbol value (taken modulo 2^SF) and up_i are captured on the start edge and again on each symbol boundary.
- R5: bw_i values 0, 1 and 2 (125k, 250k and 500k) multiply the phase step by 1, 2 and 4, and the value 3 acts as 2. The number of samples per symbol does not depend on bw_i.
- R6: In a symbol begun with cont_i low, a sample refused by m_ready_i low stays on m_data_o unchanged, with m_valid_o high, until it is accepted. No sample is skipped.
- R7: When the last sample of a symbol leaves, a new symbol begins on the next cycle if cont_i is high, and the phase carries on. Otherwise busy_o falls and done_o rises, and done_o stays high until an accepted start or a reset.
- R8: In a symbol begun with cont_i high, the sequence advances every cycle. A sample not accepted is lost and sets overflow_o. overflow_o stays set until an accepted start or a reset.
- R9: A start pulse while busy_o is high has no effect on the sample sequence or the status.
- R10: rst_n low (asynchronous) or soft_rst_i high (synchronous, one cycle) returns the block to idle with busy_o, done_o, overflow_o and m_valid_o all low.
- R11: done_o and busy_o are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| soft_rst_i | input | 1 | Synchronous return to idle |
| start_i | input | 1 | Begin a symbol (ignored while busy) |
| sf_i | input | 4 | Spreading factor, clamped to 5..12 |
| sym_i | input | 12 | Symbol value (start-bin offset) |
| up_i | input | 1 | 1 = rising sweep, 0 = falling sweep |
| cont_i | input | 1 | Repeat: another symbol follows and no stalling |
| bw_i | input | 2 | Bandwidth select, scales the phase step |
| m_valid_o | output | 1 | Sample available |
| m_ready_i | input | 1 | Consumer takes the sample |
| m_data_o | output | 32 | I in 31:16, Q in 15:0, signed |
| done_o | output | 1 | Last symbol finished (sticky) |
| busy_o | output | 1 | Symbol in progress |
| overflow_o | output | 1 | A continuous-mode sample was lost (sticky) |

## Verification
Every combination of SF 5 to 7, three symbol values (0, 5 and the top bin), both directions and all three bandwidths is swept through a complete symbol, and each sample is compared against an arithmetic model of the phase. A wrong wrap point, a mirror that is off by one, or a wrong shift shows up there as a phase drift. Clamped SF values separate the length rule from the sweep rule. A ready pattern that is low one cycle in three separates stalling from dropping, since the single-shot sequence must stay intact while a refusal in continuous mode must advance the sequence and set overflow. Back-to-back continuous symbols with a new symbol and direction applied mid-stream show that the inputs are sampled only at the boundary and that the phase carries over it.

// File: rtl/chirp_pkg.sv
`timescale 1ns/1ps
package chirp_pkg;
  localparam int SF_MIN = 5;
  localparam int SF_MAX = 12;
  localparam int SF_W   = 4;
  localparam int SYM_W  = SF_MAX;
  localparam int BW_W   = 2;
  localparam int BW_MAX = 2;

  function automatic logic [SF_W-1:0] clamp_sf(input logic [SF_W-1:0] s);
    if (s < SF_W'(SF_MIN)) return SF_W'(SF_MIN);
    if (s > SF_W'(SF_MAX)) return SF_W'(SF_MAX);
    return s;
  endfunction

  function automatic logic [BW_W-1:0] clamp_bw(input logic [BW_W-1:0] b);
    return (b > BW_W'(BW_MAX)) ? BW_W'(BW_MAX) : b;
  endfunction
endpackage

// File: rtl/chirp_freq_step.sv
`timescale 1ns/1ps
// Maps sample index to the per-sample phase increment.
// PHASE_W must be at least SF_MAX + 2 so the shift never goes negative.
module chirp_freq_step
  import chirp_pkg::*;
#(
  parameter int PHASE_W = 16
) (
  input  logic [SYM_W-1:0]   idx,
  input  logic [SYM_W-1:0]   sym,
  input  logic               up,
  input  logic [SF_W-1:0]    sf,
  input  logic [BW_W-1:0]    bw,
  output logic [PHASE_W-1:0] inc,
  output logic [SYM_W-1:0]   last
);
  logic [SYM_W-1:0] bin_sum;
  logic [SYM_W-1:0] bin;
  logic [7:0]       shamt;

  always_comb begin
    last    = ~({SYM_W{1'b1}} << sf);
    bin_sum = (sym + idx) & last;
    bin     = up ? bin_sum : (last - bin_sum);
    shamt   = 8'(PHASE_W - 2) - 8'(sf) + 8'(bw);
    inc     = PHASE_W'(bin) << shamt;
  end
endmodule

// File: rtl/chirp_sincos.sv
`timescale 1ns/1ps
// Quarter-wave table lookup: one table, both quadrature outputs.
module chirp_sincos #(
  parameter int LUT_BITS = 8,
  parameter int OUT_W    = 16
) (
  input  logic [LUT_BITS-1:0]     pidx,
  output logic signed [OUT_W-1:0] cos_o,
  output logic signed [OUT_W-1:0] sin_o
);
  localparam int  QTR     = 1 << (LUT_BITS - 2);
  localparam int  AW      = LUT_BITS - 1;
  localparam real AMP     = real'((1 << (OUT_W - 1)) - 1);
  localparam real HALF_PI = 1.5707963267948966;

  logic signed [OUT_W-1:0] qtab [0:QTR];

  for (genvar g = 0; g <= QTR; g++) begin : g_tab
    localparam int TV = $rtoi(AMP * $sin(HALF_PI * real'(g) / real'(QTR)) + 0.5);
    assign qtab[g] = TV[OUT_W-1:0];
  end

  logic [1:0]          quad_s, quad_c;
  logic [LUT_BITS-3:0] off;
  logic [AW-1:0]       addr_s, addr_c;

  always_comb begin
    quad_s = pidx[LUT_BITS-1 -: 2];
    quad_c = quad_s + 2'd1;
    off    = pidx[LUT_BITS-3:0];
    addr_s = quad_s[0] ? (AW'(QTR) - AW'(off)) : AW'(off);
    addr_c = quad_c[0] ? (AW'(QTR) - AW'(off)) : AW'(off);
    sin_o  = quad_s[1] ? -qtab[addr_s] : qtab[addr_s];
    cos_o  = quad_c[1] ? -qtab[addr_c] : qtab[addr_c];
  end
endmodule

// File: rtl/chirp_seq.sv
`timescale 1ns/1ps
// Symbol sequencing, phase accumulation and status.
module chirp_seq
  import chirp_pkg::*;
#(
  parameter int PHASE_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               soft_rst,
  input  logic               start,
  input  logic [SF_W-1:0]    sf_in,
  input  logic [SYM_W-1:0]   sym_in,
  input  logic               up_in,
  input  logic               cont_in,
  input  logic [BW_W-1:0]    bw_in,
  input  logic               ready,
  input  logic [PHASE_W-1:0] inc,
  input  logic [SYM_W-1:0]   last,
  output logic [SYM_W-1:0]   n_q,
  output logic [SYM_W-1:0]   sym_q,
  output logic               up_q,
  output logic [SF_W-1:0]    sf_q,
  output logic [BW_W-1:0]    bw_q,
  output logic [PHASE_W-1:0] phase_q,
  output logic               cont_q,
  output logic               busy,
  output logic               done,
  output logic               ovf
);
  logic advance;
  assign advance = busy && (ready || cont_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; done <= 1'b0; ovf <= 1'b0; cont_q <= 1'b0;
      n_q <= '0; sym_q <= '0; up_q <= 1'b1; phase_q <= '0;
      sf_q <= SF_W'(SF_MIN); bw_q <= '0;
    end else if (soft_rst) begin
      busy <= 1'b0; done <= 1'b0; ovf <= 1'b0; cont_q <= 1'b0;
      n_q <= '0; phase_q <= '0;
    end else if (start && !busy) begin
      busy    <= 1'b1;
      done    <= 1'b0;
      ovf     <= 1'b0;
      n_q     <= '0;
      phase_q <= '0;
      sf_q    <= clamp_sf(sf_in);
      bw_q    <= clamp_bw(bw_in);
      sym_q   <= sym_in;
      up_q    <= up_in;
      cont_q  <= cont_in;
    end else if (busy) begin
      if (cont_q && !ready) ovf <= 1'b1;
      if (advance) begin
        phase_q <= phase_q + inc;
        if (n_q == last) begin
          n_q <= '0;
          if (cont_in) begin
            sym_q  <= sym_in;
            up_q   <= up_in;
            cont_q <= 1'b1;
          end else begin
            busy <= 1'b0;
            done <= 1'b1;
          end
        end else begin
          n_q <= n_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/chirp_symbol_gen.sv
`timescale 1ns/1ps
module chirp_symbol_gen
  import chirp_pkg::*;
#(
  parameter int PHASE_W  = 16,
  parameter int LUT_BITS = 8,
  parameter int OUT_W    = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 soft_rst_i,
  input  logic                 start_i,
  input  logic [SF_W-1:0]      sf_i,
  input  logic [SYM_W-1:0]     sym_i,
  input  logic                 up_i,
  input  logic                 cont_i,
  input  logic [BW_W-1:0]      bw_i,
  output logic                 m_valid_o,
  input  logic                 m_ready_i,
  output logic [2*OUT_W-1:0]   m_data_o,
  output logic                 done_o,
  output logic                 busy_o,
  output logic                 overflow_o
);
  logic [SYM_W-1:0]        n_q, sym_q, last;
  logic                    up_q, mode_cont;
  logic [SF_W-1:0]         sf_q;
  logic [BW_W-1:0]         bw_q;
  logic [PHASE_W-1:0]      phase_q, inc;
  logic signed [OUT_W-1:0] i_s, q_s;

  chirp_seq #(.PHASE_W(PHASE_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst_i), .start(start_i),
    .sf_in(sf_i), .sym_in(sym_i), .up_in(up_i), .cont_in(cont_i), .bw_in(bw_i),
    .ready(m_ready_i), .inc(inc), .last(last),
    .n_q(n_q), .sym_q(sym_q), .up_q(up_q), .sf_q(sf_q), .bw_q(bw_q),
    .phase_q(phase_q), .cont_q(mode_cont),
    .busy(busy_o), .done(done_o), .ovf(overflow_o)
  );

  chirp_freq_step #(.PHASE_W(PHASE_W)) u_step (
    .idx(n_q), .sym(sym_q), .up(up_q), .sf(sf_q), .bw(bw_q),
    .inc(inc), .last(last)
  );

  chirp_sincos #(.LUT_BITS(LUT_BITS), .OUT_W(OUT_W)) u_lut (
    .pidx(phase_q[PHASE_W-1 -: LUT_BITS]), .cos_o(i_s), .sin_o(q_s)
  );

  assign m_valid_o = busy_o;
  assign m_data_o  = {i_s, q_s};
endmodule

// File: rtl/chirp_symbol_gen_checker.sv
`timescale 1ns/1ps
module chirp_symbol_gen_checker #(
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          soft_rst_i,
  input logic          start_i,
  input logic          m_valid_o,
  input logic          m_ready_i,
  input logic [DW-1:0] m_data_o,
  input logic          done_o,
  input logic          busy_o,
  input logic          overflow_o,
  input logic          mode_cont
);
  localparam logic [DW-1:0] FIRST = {1'b0, {(DW/2-1){1'b1}}, {(DW/2){1'b0}}};

  assert_idle_exclusive_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_o && busy_o));

  assert_first_sample_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> (m_data_o == FIRST));

  assert_stall_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !mode_cont && !m_ready_i && !soft_rst_i) |=> ($stable(m_data_o) && m_valid_o));

  assert_ovf_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (overflow_o && !soft_rst_i && !(start_i && !busy_o)) |=> overflow_o);

  assert_ovf_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overflow_o) |-> $past(m_valid_o && !m_ready_i && mode_cont));

  assert_done_after_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_o) |-> $past(busy_o));

  assert_soft_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst_i |=> (!busy_o && !done_o && !overflow_o));
endmodule

bind chirp_symbol_gen chirp_symbol_gen_checker #(.DW(2*OUT_W)) u_chk (.*);

// File: tb/chirp_symbol_gen_bench.sv
`timescale 1ns/1ps
module chirp_symbol_gen_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic        soft_r = 0, start_r = 0, up_r = 1, cont_r = 0, rdy_r = 1;
  logic [3:0]  sf_r = 4'd5;
  logic [11:0] sym_r = '0;
  logic [1:0]  bw_r = '0;

  logic        m_valid_o, done_o, busy_o, overflow_o;
  logic [31:0] m_data_o;

  chirp_symbol_gen u_chirp_symbol_gen (
    .clk(clk), .rst_n(rst_n), .soft_rst_i(soft_r), .start_i(start_r),
    .sf_i(sf_r), .sym_i(sym_r), .up_i(up_r), .cont_i(cont_r), .bw_i(bw_r),
    .m_valid_o(m_valid_o), .m_ready_i(rdy_r), .m_data_o(m_data_o),
    .done_o(done_o), .busy_o(busy_o), .overflow_o(overflow_o)
  );

  int total = 0, bad = 0, beats = 0;
  int m_busy = 0, m_done = 0, m_ovf = 0, m_n = 0, m_phase = 0;
  int m_sf = 5, m_bw = 0, m_sym = 0, m_up = 1, m_cont = 0;
  string dtag = "R3";

  function automatic int clampsf(int s);
    return (s < 5) ? 5 : ((s > 12) ? 12 : s);
  endfunction

  function automatic int rnd(real x);
    return (x >= 0.0) ? $rtoi(x + 0.5) : -$rtoi(-x + 0.5);
  endfunction

  task automatic check(bit ok, string req, longint act, longint exp, string what);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Check outputs mid-cycle, model the coming edge, move to next negedge.
  task automatic cyc();
    int idx, ei, eq, di, dq, nn, sum, k;
    check(busy_o === (m_busy != 0), "R1", busy_o, m_busy, "busy");
    check(m_valid_o === (m_busy != 0), "R1", m_valid_o, m_busy, "valid");
    check(done_o === (m_done != 0), "R7", done_o, m_done, "done");
    check(overflow_o === (m_ovf != 0), "R8", overflow_o, m_ovf, "overflow");
    check(!(done_o && busy_o), "R11", done_o, 0, "done with busy");
    if (m_busy != 0) begin
      idx = m_phase >> 8;
      ei = rnd(32767.0 * $cos(6.283185307179586 * real'(idx) / 256.0));
      eq = rnd(32767.0 * $sin(6.283185307179586 * real'(idx) / 256.0));
      di = int'($signed(m_data_o[31:16]));
      dq = int'($signed(m_data_o[15:0]));
      check((di - ei) <= 1 && (ei - di) <= 1, dtag, di, ei, "I sample");
      check((dq - eq) <= 1 && (eq - dq) <= 1, dtag, dq, eq, "Q sample");
    end
    if (m_valid_o && rdy_r) beats++;
    if (soft_r) begin
      m_busy = 0; m_done = 0; m_ovf = 0;
    end else if (start_r && m_busy == 0) begin
      m_busy = 1; m_done = 0; m_ovf = 0; m_n = 0; m_phase = 0;
      m_sf = clampsf(int'(sf_r)); m_bw = (bw_r > 2) ? 2 : int'(bw_r);
      m_sym = int'(sym_r); m_up = int'(up_r); m_cont = int'(cont_r);
    end else if (m_busy != 0) begin
      if (m_cont != 0 && !rdy_r) m_ovf = 1;
      if (rdy_r || m_cont != 0) begin
        nn = 1 << m_sf;
        sum = (m_sym + m_n) % nn;
        k = (m_up != 0) ? sum : (nn - 1 - sum);
        m_phase = (m_phase + (k << (14 - m_sf + m_bw))) % 65536;
        if (m_n == nn - 1) begin
          m_n = 0;
          if (cont_r) begin
            m_sym = int'(sym_r); m_up = int'(up_r); m_cont = 1;
          end else begin
            m_busy = 0; m_done = 1;
          end
        end else m_n++;
      end
    end
    @(negedge clk);
  endtask

  // One single-shot symbol; rmode 1 = ready low one cycle in three; poke = start while busy.
  task automatic run_sym(int sf, int sym, int up, int bw, int rmode, int poke);
    sf_r = 4'(sf); sym_r = 12'(sym); up_r = up[0]; bw_r = 2'(bw); cont_r = 0;
    rdy_r = 1; beats = 0; start_r = 1;
    cyc();
    start_r = 0;
    check(m_data_o == 32'h7FFF_0000, "R1", m_data_o, 32'h7FFF_0000, "first sample");
    for (int c = 0; m_busy != 0 && c < 20000; c++) begin
      rdy_r = (rmode != 0) ? ((c % 3) != 2) : 1'b1;
      if (poke != 0 && c == 7) begin start_r = 1; sym_r = 12'(sym + 3); end
      else start_r = 0;
      cyc();
    end
    rdy_r = 1; start_r = 0;
    check(beats == (1 << clampsf(sf)), "R2", beats, 1 << clampsf(sf), "samples per symbol");
    check(done_o == 1'b1, "R7", done_o, 1, "done after symbol");
  endtask

  initial begin
    #(4 * 190000);
    total++; bad++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    check(busy_o == 0 && done_o == 0 && overflow_o == 0 && m_valid_o == 0,
          "R10", {busy_o, done_o, overflow_o, m_valid_o}, 0, "reset state");
    rst_n = 1;
    cyc(); cyc();

    // Sweep: SF 5..7, three symbols, both directions, three bandwidths (R3 R4 R5)
    for (int sf = 5; sf <= 7; sf++)
      for (int s = 0; s < 3; s++)
        for (int up = 0; up < 2; up++)
          for (int bw = 0; bw < 3; bw++) begin
            dtag = (bw != 0) ? "R5" : ((up != 0) ? "R3" : "R4");
            run_sym(sf, (s == 0) ? 0 : ((s == 1) ? 5 : (1 << sf) - 1), up, bw, 0, 0);
            cyc();
          end

    // Clamping (R2, R5)
    dtag = "R2";
    run_sym(3, 7, 1, 0, 0, 0);
    run_sym(15, 100, 0, 1, 0, 0);
    dtag = "R5";
    run_sym(5, 9, 1, 3, 0, 0);
    cyc(); cyc();
    check(done_o == 1'b1, "R7", done_o, 1, "done held while idle");

    // Back-pressure in single mode (R6)
    dtag = "R6";
    run_sym(6, 9, 1, 1, 1, 0);

    // Start while busy ignored (R9)
    dtag = "R9";
    run_sym(5, 11, 0, 2, 0, 1);

    // Continuous: two symbols, new symbol/direction taken at boundary (R7, R4)
    dtag = "R4";
    sf_r = 5; sym_r = 2; up_r = 1; bw_r = 1; cont_r = 1; rdy_r = 1; beats = 0;
    start_r = 1; cyc(); start_r = 0;
    for (int c = 0; m_busy != 0 && c < 500; c++) begin
      if (c == 5) begin sym_r = 20; up_r = 0; end
      if (c == 40) cont_r = 0;
      cyc();
    end
    check(beats == 64, "R7", beats, 64, "samples over two continuous symbols");

    // Overflow in continuous mode (R8)
    dtag = "R8";
    sf_r = 5; sym_r = 4; up_r = 1; bw_r = 0; cont_r = 1; rdy_r = 1;
    start_r = 1; cyc(); start_r = 0;
    for (int c = 0; m_busy != 0 && c < 500; c++) begin
      rdy_r = (c != 3);
      if (c == 10) cont_r = 0;
      cyc();
      if (c == 3) check(overflow_o == 1'b1, "R8", overflow_o, 1, "overflow on refused sample");
    end
    cyc();
    check(overflow_o == 1'b1, "R8", overflow_o, 1, "overflow sticky after end");
    sf_r = 5; cont_r = 0; start_r = 1; cyc(); start_r = 0;
    check(overflow_o == 1'b0, "R8", overflow_o, 0, "overflow cleared by start");
    for (int c = 0; m_busy != 0 && c < 500; c++) cyc();

    // Soft reset mid-symbol (R10)
    dtag = "R10";
    sf_r = 6; sym_r = 1; start_r = 1; cyc(); start_r = 0;
    for (int c = 0; c < 5; c++) cyc();
    soft_r = 1; cyc(); soft_r = 0;
    check(busy_o == 0 && done_o == 0 && overflow_o == 0 && m_valid_o == 0,
          "R10", {busy_o, done_o, overflow_o, m_valid_o}, 0, "soft reset idle");
    cyc(); cyc();

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule